// File: doc/BRIEF.md
# Dual Stretched Reset Generator

This block drives two active-low system resets and an active-low health flag. The inputs are six per-channel fault flags, a manual reset pin, a longdog timeout request with its kick, and the state of the power-on sequencer. Each reset has its own 6-bit mask that picks which channel faults can assert it. Once every cause for a reset has gone away, the reset stays asserted for a programmed hold time. The hold time is 25, 50, 100 or 200 ms, selected by a 2-bit code.

The early reset (`rst_a_n`) can leave reset partway through power-on. This happens when one of a chosen set of supply enables turns on, so that one part of the system can start before the rest. The late reset (`rst_b_n`) stays asserted until the whole sequence has finished, and then for the hold time. A longdog request asserts both resets. That hold ends on a kick or at the timeout, whichever comes first.

The block also produces a one-cycle release pulse for each reset, used by the supervisor to clear its interrupt and restart its timers. Two further outputs gate writes: one blocks writes to non-volatile memory, and one permits writes to configuration registers.

Top module: `rst_stretch_gen`

## Requirements
- R1: Block reset asserts both resets. Every hold lasts `TICKS_PER_MS*BASE_MS << tmo_code` clock cycles, counted from the first cycle in which no cause is present. The code values are 0, 1, 2 and 3, which give 25, 50, 100 and 200 ms by default.
- R2: `mr_n` low asserts both resets in the next cycle. No mask can stop this. Both resets stay asserted while `mr_n` is low and for the hold time after it returns high, and both release together.
- R3: A channel fault (`chan_fault[i]`=1) asserts `rst_a_n` only if `fault_en_a[i]`=1, and asserts `rst_b_n` only if `fault_en_b[i]`=1. The reset stays asserted while the fault lasts, and then for the hold time.
- R4: While `seq_busy` is 1, `rst_b_n` is asserted. After `seq_busy` falls, `rst_b_n` is released once the hold time has elapsed.
- R5: While `seq_busy` is 1, `rst_a_n` is also asserted until `pup_on & early_sel` becomes nonzero. On that rising edge, if `rst_a_n` is asserted and no fault or manual cause for it is present, `rst_a_n` is released in the next cycle with no hold time.
- R6: If a fault or manual cause for `rst_a_n` is present when the selected enable turns on, no early release happens. `rst_a_n` then follows the normal hold time after that cause ends.
- R7: A `ldog_req` pulse asserts both resets. The longdog hold ends in the cycle after a `kick` pulse, or after the hold time if no kick comes.
- R8: A `kick` does not shorten a hold that was caused by a fault or by manual reset.
- R9: If a cause returns during a hold, the hold count restarts from zero.
- R10: `healthy_n` is 0 exactly when no bit of `chan_fault` is 1.
- R11: `nvm_wr_block` is 1 while either reset is asserted or `mr_n` is low. `cfg_wr_ok` is 1 only while `mr_n` is low.
- R12: `rel_a` and `rel_b` pulse high for one cycle, in the first cycle in which the matching reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low |
| chan_fault | input | NCH | Per-channel fault, 1 = fault |
| mr_n | input | 1 | Manual reset, active low |
| ldog_req | input | 1 | Longdog timeout pulse |
| kick | input | 1 | Kick pulse, already edge-detected |
| seq_busy | input | 1 | Power-on sequence in progress |
| pup_on | input | NCH | Supply enables currently active |
| fault_en_a | input | NCH | Fault mask for the early reset |
| fault_en_b | input | NCH | Fault mask for the late reset |
| early_sel | input | NCH | Enables that may release the early reset |
| tmo_code | input | 2 | Hold time select |
| rst_a_n | output | 1 | Early reset, active low |
| rst_b_n | output | 1 | Late reset, active low |
| rel_a | output | 1 | Early reset release pulse |
| rel_b | output | 1 | Late reset release pulse |
| healthy_n | output | 1 | 0 when no channel is faulted |
| nvm_wr_block | output | 1 | Inhibit for non-volatile memory writes |
| cfg_wr_ok | output | 1 | Permission for configuration writes |

## Verification
The hold length is measured for each of the four codes, after faults, after manual reset, after a longdog request and after a sequence ends. This separates a wrong code decode from an off-by-one count. A fault is placed on channels that are enabled for only one reset and on a channel enabled for neither, which shows that the two masks act independently. Power-on runs are repeated three ways: with an unselected enable, with a selected enable, and with a selected enable while a fault is present. This separates early release from release by timeout. A kick is applied both during a longdog hold and during a fault hold, and a mid-hold retrigger is used to show that the hold count restarts.

// File: rtl/rst_stretch_gen.sv
module rst_stretch_gen #(
  parameter int NCH = 6,
  parameter int TICKS_PER_MS = 1000,
  parameter int BASE_MS = 25
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_fault,
  input  logic           mr_n,
  input  logic           ldog_req,
  input  logic           kick,
  input  logic           seq_busy,
  input  logic [NCH-1:0] pup_on,
  input  logic [NCH-1:0] fault_en_a,
  input  logic [NCH-1:0] fault_en_b,
  input  logic [NCH-1:0] early_sel,
  input  logic [1:0]     tmo_code,
  output logic           rst_a_n,
  output logic           rst_b_n,
  output logic           rel_a,
  output logic           rel_b,
  output logic           healthy_n,
  output logic           nvm_wr_block,
  output logic           cfg_wr_ok
);
  localparam int BASE_T = TICKS_PER_MS * BASE_MS;
  localparam int CW = $clog2(BASE_T * 8 + 1);

  logic [CW-1:0] lim;
  logic          early_go, early_q, early_rise;
  logic          trig [2];
  logic          fast [2];
  logic          asrt [2];
  logic          ldog [2];
  logic          rel  [2];
  logic [CW-1:0] cnt  [2];

  assign lim        = CW'(BASE_T) << tmo_code;
  assign early_go   = |(pup_on & early_sel);
  assign early_rise = seq_busy & early_go & ~early_q;

  assign trig[0] = ~mr_n | (|(chan_fault & fault_en_a)) | (seq_busy & ~early_go);
  assign trig[1] = ~mr_n | (|(chan_fault & fault_en_b)) | seq_busy;
  assign fast[0] = early_rise;
  assign fast[1] = 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) early_q <= 1'b0;
    else        early_q <= seq_busy & early_go;

  for (genvar i = 0; i < 2; i++) begin : g_rst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        asrt[i] <= 1'b1;
        ldog[i] <= 1'b0;
        rel[i]  <= 1'b0;
        cnt[i]  <= '0;
      end else begin
        rel[i] <= 1'b0;
        if (trig[i]) begin
          asrt[i] <= 1'b1;
          ldog[i] <= 1'b0;
          cnt[i]  <= '0;
        end else if (ldog_req) begin
          asrt[i] <= 1'b1;
          ldog[i] <= 1'b1;
          cnt[i]  <= '0;
        end else if (asrt[i] && (fast[i] || (ldog[i] && kick) || cnt[i] == lim - CW'(1))) begin
          asrt[i] <= 1'b0;
          ldog[i] <= 1'b0;
          rel[i]  <= 1'b1;
          cnt[i]  <= '0;
        end else if (asrt[i]) begin
          cnt[i] <= cnt[i] + CW'(1);
        end
      end
    end
  end

  assign rst_a_n      = ~asrt[0];
  assign rst_b_n      = ~asrt[1];
  assign rel_a        = rel[0];
  assign rel_b        = rel[1];
  assign healthy_n    = |chan_fault;
  assign nvm_wr_block = asrt[0] | asrt[1] | ~mr_n;
  assign cfg_wr_ok    = ~mr_n;
endmodule

// File: rtl/rst_stretch_gen_chk.sv
module rst_stretch_gen_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_fault,
  input logic           mr_n,
  input logic           ldog_req,
  input logic           seq_busy,
  input logic [NCH-1:0] fault_en_a,
  input logic [NCH-1:0] fault_en_b,
  input logic           rst_a_n,
  input logic           rst_b_n,
  input logic           rel_a,
  input logic           rel_b,
  input logic           nvm_wr_block
);
  AST_MR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_n |=> (!rst_a_n && !rst_b_n)); // R2
  AST_MR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_a_n) |-> $past(mr_n)); // R2
  AST_FAULT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chan_fault & fault_en_a)) |=> !rst_a_n); // R3
  AST_FAULT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chan_fault & fault_en_b)) |=> !rst_b_n); // R3
  AST_SEQ_HOLDS_B: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> !rst_b_n); // R4
  AST_LDOG_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    ldog_req |=> (!rst_a_n && !rst_b_n)); // R7
  AST_NVM_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_a_n || !rst_b_n || !mr_n) |-> nvm_wr_block); // R11
  AST_REL_A_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_a |-> (rst_a_n && $past(!rst_a_n))); // R12
  AST_REL_B_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_b |-> (rst_b_n && $past(!rst_b_n))); // R12
endmodule

bind rst_stretch_gen rst_stretch_gen_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_fault(chan_fault), .mr_n(mr_n),
  .ldog_req(ldog_req), .seq_busy(seq_busy), .fault_en_a(fault_en_a),
  .fault_en_b(fault_en_b), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
  .rel_a(rel_a), .rel_b(rel_b), .nvm_wr_block(nvm_wr_block)
);

// File: tb/rst_stretch_gen_tb.sv
module rst_stretch_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int TPM = 1;
  localparam int BMS = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] chan_fault = '0, pup_on = '0;
  logic [NCH-1:0] fault_en_a = '0, fault_en_b = '0, early_sel = '0;
  logic mr_n = 1'b1, ldog_req = 1'b0, kick = 1'b0, seq_busy = 1'b0;
  logic [1:0] tmo_code = 2'd0;
  logic rst_a_n, rst_b_n, rel_a, rel_b, healthy_n, nvm_wr_block, cfg_wr_ok;

  int checks = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_stretch_gen #(.NCH(NCH), .TICKS_PER_MS(TPM), .BASE_MS(BMS)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_fault(chan_fault), .mr_n(mr_n),
    .ldog_req(ldog_req), .kick(kick), .seq_busy(seq_busy), .pup_on(pup_on),
    .fault_en_a(fault_en_a), .fault_en_b(fault_en_b), .early_sel(early_sel),
    .tmo_code(tmo_code), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
    .rel_a(rel_a), .rel_b(rel_b), .healthy_n(healthy_n),
    .nvm_wr_block(nvm_wr_block), .cfg_wr_ok(cfg_wr_ok));

  task automatic push(string tag, int v);
    tag_q.push_back(tag);
    exp_q.push_back(v);
  endtask

  task automatic pop_cmp(int act);
    string t;
    int e;
    t = tag_q.pop_front();
    e = exp_q.pop_front();
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, e);
    end
  endtask

  task automatic chk(string tag, int act, int e);
    push(tag, e);
    pop_cmp(act);
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic int hold(int code);
    return (TPM * BMS) << code;
  endfunction

  task automatic measure(input bit which_b, input int start, input string tag, input int e);
    int n;
    n = start;
    push(tag, e);
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      n++;
      if ((which_b ? rst_b_n : rst_a_n) === 1'b1) break;
    end
    pop_cmp(n);
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 reset state a", rst_a_n, 0);
    chk("R1 reset state b", rst_b_n, 0);
    chk("R12 no pulse in reset", rel_a, 0);
    chk("R10 healthy", healthy_n, 0);
    rst_n = 1'b1;
    measure(0, 0, "R1 power-up hold a", hold(0));
    chk("R1 b released with a", rst_b_n, 1);
    chk("R12 rel_a pulse", rel_a, 1);
    chk("R12 rel_b pulse", rel_b, 1);
    cyc(1);
    chk("R12 rel_a one cycle", rel_a, 0);
    chk("R11 nvm free", nvm_wr_block, 0);
    chk("R11 cfg closed", cfg_wr_ok, 0);

    fault_en_a = 6'b000001;
    for (int c = 1; c < 4; c++) begin
      tmo_code = 2'(c);
      chan_fault = 6'b000001;
      cyc(2);
      chk("R3 fault a asserts a", rst_a_n, 0);
      chk("R3 fault a spares b", rst_b_n, 1);
      chk("R10 unhealthy", healthy_n, 1);
      chan_fault = '0;
      measure(0, 0, "R1 hold per code", hold(c));
    end
    tmo_code = 2'd0;

    fault_en_b = 6'b100000;
    chan_fault = 6'b100000;
    cyc(2);
    chk("R3 fault b asserts b", rst_b_n, 0);
    chk("R3 fault b spares a", rst_a_n, 1);
    chan_fault = '0;
    measure(1, 0, "R3 hold b", hold(0));
    chan_fault = 6'b010000;
    cyc(2);
    chk("R3 unmasked a", rst_a_n, 1);
    chk("R3 unmasked b", rst_b_n, 1);
    chk("R10 unhealthy unmasked", healthy_n, 1);
    chan_fault = '0;
    cyc(1);

    mr_n = 1'b0;
    cyc(1);
    chk("R2 mr a", rst_a_n, 0);
    chk("R2 mr b", rst_b_n, 0);
    chk("R11 nvm blocked by mr", nvm_wr_block, 1);
    chk("R11 cfg open", cfg_wr_ok, 1);
    cyc(4);
    mr_n = 1'b1;
    cyc(1);
    chk("R11 nvm blocked in hold", nvm_wr_block, 1);
    chk("R11 cfg closed in hold", cfg_wr_ok, 0);
    measure(0, 1, "R2 mr hold", hold(0));
    chk("R2 b released together", rst_b_n, 1);

    chan_fault = 6'b000001;
    cyc(1);
    chan_fault = '0;
    cyc(10);
    chan_fault = 6'b000001;
    cyc(1);
    chan_fault = '0;
    measure(0, 0, "R9 restart", hold(0));

    ldog_req = 1'b1;
    cyc(1);
    ldog_req = 1'b0;
    chk("R7 ldog a", rst_a_n, 0);
    chk("R7 ldog b", rst_b_n, 0);
    cyc(5);
    kick = 1'b1;
    cyc(1);
    kick = 1'b0;
    chk("R7 kick ends a", rst_a_n, 1);
    chk("R7 kick ends b", rst_b_n, 1);
    chk("R12 rel_b on kick", rel_b, 1);
    ldog_req = 1'b1;
    cyc(1);
    ldog_req = 1'b0;
    measure(0, 0, "R7 ldog timeout", hold(0));

    chan_fault = 6'b000001;
    cyc(2);
    chan_fault = '0;
    kick = 1'b1;
    cyc(1);
    kick = 1'b0;
    chk("R8 kick ignored", rst_a_n, 0);
    measure(0, 1, "R8 fault hold kept", hold(0));

    fault_en_a = '0; fault_en_b = '0;
    early_sel = 6'b000100;
    seq_busy = 1'b1;
    cyc(1);
    chk("R4 seq b", rst_b_n, 0);
    chk("R5 seq a", rst_a_n, 0);
    pup_on = 6'b000001;
    cyc(2);
    chk("R5 unselected enable", rst_a_n, 0);
    pup_on = 6'b000101;
    cyc(1);
    chk("R5 early release", rst_a_n, 1);
    chk("R12 rel_a early", rel_a, 1);
    chk("R4 b still held", rst_b_n, 0);
    cyc(3);
    chk("R5 a stays released", rst_a_n, 1);
    seq_busy = 1'b0;
    measure(1, 0, "R4 b hold after seq", hold(0));
    pup_on = '0;
    cyc(2);

    fault_en_a = 6'b000010;
    seq_busy = 1'b1;
    chan_fault = 6'b000010;
    cyc(2);
    pup_on = 6'b000100;
    cyc(2);
    chk("R6 no early release", rst_a_n, 0);
    chan_fault = '0;
    measure(0, 0, "R6 normal hold", hold(0));
    seq_busy = 1'b0;
    pup_on = '0;
    cyc(hold(0) + 3);
    chk("R4 b released", rst_b_n, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule